// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for a signal-processing datapath that walks through data buffers with pointers. It keeps four pointer sets. Each set has a 14-bit index, a 14-bit modify step and a 14-bit length. Software loads and reads these registers over a 16-bit register bus. On an indirect access the caller picks one index and one modify register. The block then puts the selected index on the address output and, on the clock edge that ends the access, writes back the index advanced by the signed modify step.

When the length paired with the selected index is non-zero, the advanced value is kept inside a circular buffer that starts on a power-of-two boundary. The block pulses a wrap flag during any access that crosses a buffer end, and a serial-port engine can use that flag as its buffer-complete interrupt. A bit-reverse option mirrors the output address. This gives the reordered addressing that radix-2 FFTs need, and it leaves the stored pointer untouched.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every index, modify and length register reads 0, the address output is 0 and the wrap flag is low.
- R2: A register write stores the low 14 bits of `regWrData` into the register chosen by `regAddr`. In `regAddr`, bits [3:2] give the kind (00 index, 01 modify, 10 length, 11 none) and bits [1:0] give the pointer. `regRdData` shows the register chosen by `regAddr` without delay, zero-extended to 16 bits. Kind 11 reads 0 and its writes change nothing.
- R3: `accAddr` always shows the index chosen by `accIdxSel` as it stands before the update, so during an access it is the pre-modify value.
- R4: With a length of 0, an access stores index + modify. The modify is read as a signed 14-bit two's-complement value and the result is taken modulo 2^14. The wrap flag stays low.
- R5: With a non-zero length L, the buffer base is the index with its low k bits cleared, where 2^k is the smallest power of two not below L. A sum at or above base+L is reduced by L.
- R6: With a non-zero length L, a sum below the base is raised by L.
- R7: `wrapEvt` is high only in a cycle that has an access whose update took the R5 or R6 correction.
- R8: When `bitRevEn` is high, `accAddr` carries the 14 index bits in reversed order (bit 0 goes to bit 13). The value written back to the index register is not reversed.
- R9: A register write to the index being accessed in the same cycle wins over the post-modify, and that access raises no wrap flag. A write to any other register does not block the access update.
- R10: Without an access or a write, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register select: kind in [3:2], pointer in [1:0] |
| regWrData | input | 16 | Register write data (low 14 bits used) |
| regRdData | output | 16 | Read data of the selected register |
| accValid | input | 1 | Indirect access this cycle |
| accIdxSel | input | 2 | Index/length pointer for the access |
| accModSel | input | 2 | Modify register for the access |
| bitRevEn | input | 1 | Bit-reverse the output address |
| accAddr | output | 14 | Access address |
| wrapEvt | output | 1 | Buffer wraparound during this access |

## Verification
The assertions check several rules on every cycle. The wrap flag never rises without an access, and never rises for a pointer whose length is 0. A written value appears on the read port in the next cycle. A register that sees no access and no write keeps the same read value. Only the bench scenarios can show the wrap arithmetic itself: the base alignment for odd lengths, corrections in both directions, length 1, linear roll-over past zero, and the write-over-update priority. The bench compares these against a behavioural model in every cycle.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
  localparam int ADDR_W  = 14;
  localparam int BUS_W   = 16;
  localparam int PTR_W   = 2;
  localparam int PTR_CNT = 1 << PTR_W;

  typedef enum logic [1:0] {
    REG_IDX  = 2'b00,
    REG_MOD  = 2'b01,
    REG_LEN  = 2'b10,
    REG_NONE = 2'b11
  } regKind_e;

  typedef struct packed {
    logic             idxWr;
    logic             modWr;
    logic             lenWr;
    logic [PTR_W-1:0] wrPtr;
    logic             postMod;
    logic [PTR_W-1:0] idxPtr;
    logic [PTR_W-1:0] modPtr;
    logic             bitRev;
  } dagStrobe_t;
endpackage

// File: rtl/circ_addr_ctrl.sv
module circ_addr_ctrl
  import circ_addr_pkg::*;
(
  input  logic             regWrEn,
  input  logic [PTR_W+1:0] regAddr,
  input  logic             accValid,
  input  logic [PTR_W-1:0] accIdxSel,
  input  logic [PTR_W-1:0] accModSel,
  input  logic             bitRevEn,
  output dagStrobe_t       strb
);
  regKind_e wrKind;

  always_comb begin
    wrKind       = regKind_e'(regAddr[PTR_W+1:PTR_W]);
    strb.wrPtr   = regAddr[PTR_W-1:0];
    strb.idxWr   = regWrEn && (wrKind == REG_IDX);
    strb.modWr   = regWrEn && (wrKind == REG_MOD);
    strb.lenWr   = regWrEn && (wrKind == REG_LEN);
    strb.idxPtr  = accIdxSel;
    strb.modPtr  = accModSel;
    strb.bitRev  = bitRevEn;
    // a same-cycle index write to the accessed pointer overrides the update
    strb.postMod = accValid && !(strb.idxWr && (strb.wrPtr == accIdxSel));
  end
endmodule

// File: rtl/circ_addr_modulus.sv
module circ_addr_modulus #(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] curIdx,
  input  logic [ADDR_W-1:0] modVal,
  input  logic [ADDR_W-1:0] lenVal,
  output logic [ADDR_W-1:0] nextIdx,
  output logic              wrapped
);
  localparam int EXT_W = ADDR_W + 3;

  logic [ADDR_W-1:0]       span;
  logic [ADDR_W-1:0]       base;
  logic signed [EXT_W-1:0] sum;
  logic signed [EXT_W-1:0] lower;
  logic signed [EXT_W-1:0] upper;
  logic signed [EXT_W-1:0] lenExt;
  logic signed [EXT_W-1:0] fixed;

  always_comb begin
    // smear (L-1) downwards to get the power-of-two alignment mask
    span = lenVal - 1'b1;
    for (int s = 1; s < ADDR_W; s = s * 2) begin
      span = span | (span >> s);
    end
    base   = curIdx & ~span;
    sum    = $signed({3'b000, curIdx}) + $signed({{3{modVal[ADDR_W-1]}}, modVal});
    lenExt = $signed({3'b000, lenVal});
    lower  = $signed({3'b000, base});
    upper  = lower + lenExt;
    wrapped = 1'b0;
    fixed   = sum;
    if (lenVal != '0) begin
      if (sum >= upper) begin
        fixed   = sum - lenExt;
        wrapped = 1'b1;
      end else if (sum < lower) begin
        fixed   = sum + lenExt;
        wrapped = 1'b1;
      end
    end
    nextIdx = fixed[ADDR_W-1:0];
  end
endmodule

// File: rtl/circ_addr_dp.sv
module circ_addr_dp
  import circ_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dagStrobe_t       strb,
  input  logic [PTR_W+1:0] regAddr,
  input  logic [BW-1:0]    regWrData,
  output logic [BW-1:0]    regRdData,
  output logic [AW-1:0]    accAddr,
  output logic             wrapEvt,
  output logic [AW-1:0]    selLen
);
  logic [AW-1:0] idxReg [PTR_CNT];
  logic [AW-1:0] modReg [PTR_CNT];
  logic [AW-1:0] lenReg [PTR_CNT];
  logic [AW-1:0] rawAddr;
  logic [AW-1:0] nextIdx;
  logic          wrapped;
  logic [AW-1:0] wrVal;
  logic [AW-1:0] rdVal;

  assign wrVal   = regWrData[AW-1:0];
  assign rawAddr = idxReg[strb.idxPtr];
  assign selLen  = lenReg[strb.idxPtr];

  circ_addr_modulus #(.ADDR_W(AW)) u_mod (
    .curIdx (rawAddr),
    .modVal (modReg[strb.modPtr]),
    .lenVal (selLen),
    .nextIdx(nextIdx),
    .wrapped(wrapped)
  );

  assign wrapEvt = strb.postMod && wrapped;

  for (genvar p = 0; p < PTR_CNT; p++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxReg[p] <= '0;
        modReg[p] <= '0;
        lenReg[p] <= '0;
      end else begin
        if (strb.idxWr && strb.wrPtr == PTR_W'(p)) begin
          idxReg[p] <= wrVal;
        end else if (strb.postMod && strb.idxPtr == PTR_W'(p)) begin
          idxReg[p] <= nextIdx;
        end
        if (strb.modWr && strb.wrPtr == PTR_W'(p)) modReg[p] <= wrVal;
        if (strb.lenWr && strb.wrPtr == PTR_W'(p)) lenReg[p] <= wrVal;
      end
    end
  end

  for (genvar b = 0; b < AW; b++) begin : g_rev
    assign accAddr[b] = strb.bitRev ? rawAddr[AW-1-b] : rawAddr[b];
  end

  always_comb begin
    unique case (regKind_e'(regAddr[PTR_W+1:PTR_W]))
      REG_IDX: rdVal = idxReg[regAddr[PTR_W-1:0]];
      REG_MOD: rdVal = modReg[regAddr[PTR_W-1:0]];
      REG_LEN: rdVal = lenReg[regAddr[PTR_W-1:0]];
      default: rdVal = '0;
    endcase
    regRdData = {{(BW-AW){1'b0}}, rdVal};
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import circ_addr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [PTR_W+1:0]     regAddr,
  input  logic [BUS_W-1:0]     regWrData,
  output logic [BUS_W-1:0]     regRdData,
  input  logic                 accValid,
  input  logic [PTR_W-1:0]     accIdxSel,
  input  logic [PTR_W-1:0]     accModSel,
  input  logic                 bitRevEn,
  output logic [ADDR_W-1:0]    accAddr,
  output logic                 wrapEvt
);
  dagStrobe_t        strb;
  logic [ADDR_W-1:0] selLen;

  circ_addr_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .accValid (accValid),
    .accIdxSel(accIdxSel),
    .accModSel(accModSel),
    .bitRevEn (bitRevEn),
    .strb     (strb)
  );

  circ_addr_dp #(.AW(ADDR_W), .BW(BUS_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .accAddr  (accAddr),
    .wrapEvt  (wrapEvt),
    .selLen   (selLen)
  );
endmodule

// File: rtl/circ_addr_chk.sv
module circ_addr_chk
  import circ_addr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [PTR_W+1:0]     regAddr,
  input logic [BUS_W-1:0]     regWrData,
  input logic [BUS_W-1:0]     regRdData,
  input logic                 accValid,
  input logic                 wrapEvt,
  input logic [ADDR_W-1:0]    selLen
);
  p_wrap_needs_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !wrapEvt);

  p_linear_no_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && selLen == '0) |-> !wrapEvt);

  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[PTR_W+1:PTR_W] != 2'b11) ##1 (regAddr == $past(regAddr))
      |-> regRdData == {{(BUS_W-ADDR_W){1'b0}}, $past(regWrData[ADDR_W-1:0])});

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !accValid) ##1 (regAddr == $past(regAddr)) |-> $stable(regRdData));

  p_none_kind_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[PTR_W+1:PTR_W] == 2'b11) |-> regRdData == '0);
endmodule

bind circ_addr_gen circ_addr_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .accValid (accValid),
  .wrapEvt  (wrapEvt),
  .selLen   (selLen)
);

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        accValid = 1'b0;
  logic [1:0]  accIdxSel = '0;
  logic [1:0]  accModSel = '0;
  logic        bitRevEn = 1'b0;
  logic [13:0] accAddr;
  logic        wrapEvt;

  int compared = 0;
  int mismatched = 0;
  int mIdx [4];
  int mMod [4];
  int mLen [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_addr_gen uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accIdxSel(accIdxSel), .accModSel(accModSel), .bitRevEn(bitRevEn),
    .accAddr(accAddr), .wrapEvt(wrapEvt)
  );

  function automatic int modelNext(int i, int m, int l, output bit w);
    int s;
    int pw;
    int base;
    s = i + ((m >= 8192) ? m - 16384 : m);
    w = 1'b0;
    if (l != 0) begin
      pw = 1;
      while (pw < l) pw = pw * 2;
      base = i - (i % pw);
      if (s >= base + l) begin s = s - l; w = 1'b1; end
      else if (s < base) begin s = s + l; w = 1'b1; end
    end
    return s & 16383;
  endfunction

  function automatic int reverse14(int v);
    int r = 0;
    for (int b = 0; b < 14; b++) if (v[b]) r = r | (1 << (13 - b));
    return r;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: inputs driven just after the falling edge, outputs sampled 1 time unit later
  task automatic cyc(string tag, bit we, int ra, int wd, bit av, int is, int ms, bit br);
    int expAddr;
    int expRd;
    int nxt;
    bit w;
    bit blocked;
    regWrEn = we; regAddr = ra[3:0]; regWrData = wd[15:0];
    accValid = av; accIdxSel = is[1:0]; accModSel = ms[1:0]; bitRevEn = br;
    #1;
    expAddr = br ? reverse14(mIdx[is]) : mIdx[is];
    case (ra[3:2])
      0: expRd = mIdx[ra[1:0]];
      1: expRd = mMod[ra[1:0]];
      2: expRd = mLen[ra[1:0]];
      default: expRd = 0;
    endcase
    nxt = modelNext(mIdx[is], mMod[ms], mLen[is], w);
    blocked = we && ra[3:2] == 0 && ra[1:0] == is;
    check(tag, int'(accAddr), expAddr, "accAddr");
    check(tag, int'(wrapEvt), (av && !blocked && w) ? 1 : 0, "wrapEvt");
    check(tag, int'(regRdData), expRd, "regRdData");
    @(posedge clk);
    if (av && !blocked) mIdx[is] = nxt;
    if (we) begin
      case (ra[3:2])
        0: mIdx[ra[1:0]] = wd & 16383;
        1: mMod[ra[1:0]] = wd & 16383;
        2: mLen[ra[1:0]] = wd & 16383;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(string tag, int kind, int ptr, int val);
    cyc(tag, 1'b1, kind * 4 + ptr, val, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic acc(string tag, int is, int ms, bit br);
    cyc(tag, 1'b0, is, 0, 1'b1, is, ms, br);
  endtask

  task automatic rd(string tag, int kind, int ptr);
    cyc(tag, 1'b0, kind * 4 + ptr, 0, 1'b0, ptr, 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired, run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin mIdx[p] = 0; mMod[p] = 0; mLen[p] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of every register and the outputs
    for (int k = 0; k < 3; k++) for (int p = 0; p < 4; p++) rd("R1", k, p);

    // R2: writes with junk in the upper bits, read back, kind 11 ignored
    for (int p = 0; p < 4; p++) wr("R2", 1, p, 16'hC000 | (p * 7 + 1));
    for (int p = 0; p < 4; p++) rd("R2", 1, p);
    cyc("R2", 1'b1, 12 + 2, 16'h1234, 1'b0, 0, 0, 1'b0);
    rd("R2", 3, 2);
    for (int p = 0; p < 4; p++) rd("R2", 2, p);

    // R3, R4: linear with positive then negative step through zero
    wr("R4", 0, 0, 100); wr("R4", 1, 0, 3); wr("R4", 2, 0, 0);
    for (int n = 0; n < 4; n++) acc("R3", 0, 0, 1'b0);
    rd("R4", 0, 0);
    check("R4", int'(regRdData), 112, "index after 4 steps");
    wr("R4", 0, 0, 2); wr("R4", 1, 1, 16384 - 5);
    acc("R4", 0, 1, 1'b0);
    rd("R4", 0, 0);
    check("R4", int'(regRdData), 16381, "linear roll below zero");

    // R5, R7: upward wrap, L=10 at base 64
    wr("R5", 0, 1, 64); wr("R5", 1, 2, 3); wr("R5", 2, 1, 10);
    for (int n = 0; n < 5; n++) acc("R5", 1, 2, 1'b0);
    rd("R5", 0, 1);
    check("R5", int'(regRdData), 69, "index after wrap");

    // R6: downward wrap, L=5 at base 32
    wr("R6", 0, 2, 32); wr("R6", 1, 3, 16384 - 4); wr("R6", 2, 2, 5);
    for (int n = 0; n < 4; n++) acc("R6", 2, 3, 1'b0);
    rd("R6", 0, 2);
    // 32 -> 33 -> 34 -> 35 -> 36 with wraps each time
    check("R6", int'(regRdData), 36, "index after downward wraps");

    // R5 corner: length 1 holds the index
    wr("R5", 0, 3, 777); wr("R5", 2, 3, 1); wr("R5", 1, 0, 1);
    acc("R5", 3, 0, 1'b0); acc("R5", 3, 0, 1'b0);
    rd("R5", 0, 3);
    check("R5", int'(regRdData), 777, "length one");

    // R8: bit reverse on output only
    wr("R8", 0, 0, 1); wr("R8", 1, 0, 1); wr("R8", 2, 0, 0);
    acc("R8", 0, 0, 1'b1);
    acc("R8", 0, 0, 1'b1);
    rd("R8", 0, 0);
    check("R8", int'(regRdData), 3, "stored index unreversed");

    // R9: write wins over update on same pointer; other pointer write does not block
    cyc("R9", 1'b1, 0 * 4 + 1, 67, 1'b1, 1, 2, 1'b0);
    rd("R9", 0, 1);
    check("R9", int'(regRdData), 67, "write priority");
    cyc("R9", 1'b1, 0 * 4 + 0, 500, 1'b1, 1, 2, 1'b0);
    rd("R9", 0, 1);
    check("R9", int'(regRdData), 70, "other pointer updates");

    // R10: idle cycles leave registers alone
    for (int n = 0; n < 4; n++) cyc("R10", 1'b0, 4, 16'hFFFF, 1'b0, 1, 2, 1'b0);
    rd("R10", 0, 1);
    check("R10", int'(regRdData), 70, "idle hold");

    // mixed random traffic against the model (R5 R6 R7 R9)
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 3)
        cyc("R7", 1'b1, $urandom_range(0, 15), $urandom_range(0, 65535) & (sel == 0 ? 16'h003F : 16'hFFFF),
            $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1));
      else
        cyc("R7", 1'b0, $urandom_range(0, 15), 0, 1'b1, $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule